// File: doc/BRIEF.md
# Complementary Dead-Time Generator

This unit takes a single raw pulse-width signal and splits it into a complementary pair for the two switches of a half bridge. The high-side drive follows the raw signal and the low-side drive follows its inverse. Whenever one drive turns off, both drives are held low for a programmable guard interval before the other drive may turn on. This interval keeps the two switches from conducting at the same moment.

The guard interval comes from a 3-bit code. Each code step is worth two system clocks, and it is always counted on the undivided system clock. The interval is taken out of the on-time of the drive that is turning on, so the period of the raw signal is preserved. An on-pulse of the raw signal that is no longer than the guard interval never reaches its drive. A raw signal held constant (0% or 100% duty) passes through with no guard interval at all. Protective forcing of the outputs is done in a separate block downstream.

Top module: `dt_comp_pair`

## Requirements
- R1: While `rst` is high at a clock edge, both drives are low after that edge and the guard counter is cleared; at the first edge after reset is released, the drive matching `pwm_raw` turns on with no guard interval.
- R2: In steady state `drv_hi` equals `pwm_raw` and `drv_lo` equals its inverse, each registered once: a level sampled at a clock edge shows on the drives right after that edge.
- R3: When a drive that is high sees the opposite raw level at an edge, both drives are low for exactly 2 × `dt_code` clocks after that edge, and then the drive matching the raw level turns on.
- R4: With `dt_code` = 0 a raw transition moves the drive from one side to the other at a single edge, with no cycle where both drives are low.
- R5: A constant raw level (0% or 100% duty) keeps its drive on continuously, with no guard interval inserted.
- R6: A raw on-pulse lasting P clocks with P ≤ 2 × `dt_code` never turns its drive on; only one guard interval of 2 × `dt_code` clocks appears, after which the drive that was turned off comes back on.
- R7: A raw on-pulse lasting P clocks with P > 2 × `dt_code` gives P − 2 × `dt_code` clocks of on-time and two guard intervals.
- R8: `drv_hi` and `drv_lo` are never high in the same cycle, for any input sequence.
- R9: The guard length is taken from `dt_code` at the edge where the turn-off happens; changing the code during an interval does not alter that interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, undivided |
| rst | input | 1 | Synchronous active-high reset |
| pwm_raw | input | 1 | Raw pulse-width signal |
| dt_code | input | 3 | Guard interval code, 2 clocks per step |
| drv_hi | output | 1 | High-side drive, follows `pwm_raw` |
| drv_lo | output | 1 | Low-side drive, follows the inverse of `pwm_raw` |

## Verification
The assertions assume that `pwm_raw` and `dt_code` are synchronous to `clk` and stable around each rising edge. They also assume that reset is applied at the start of the run, so the past-value checks only look at cycles after it. The bench changes every input on the falling edge and samples the drives on the falling edge, which keeps it within those assumptions. The stimulus covers code values 0, 1, 3 and 7, pulses just at and just beyond the guard length, and a code change during an interval.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int DT_CODE_W    = 3;
    localparam int DT_STEP_CLKS = 2;

    typedef enum logic [1:0] {
        LEG_IDLE = 2'b00,
        LEG_HIGH = 2'b01,
        LEG_LOW  = 2'b10
    } leg_e;

    function automatic leg_e leg_for(input logic level);
        return level ? LEG_HIGH : LEG_LOW;
    endfunction

endpackage

// File: rtl/dt_interval_timer.sv
module dt_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q <= CNT_W'(1));

    a_r1_timer_cleared: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

    a_r9_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

    a_r3_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/dt_leg_steer.sv
module dt_leg_steer
    import dt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic zero_dt,
    input  logic expired,
    output leg_e leg,
    output logic load
);

    leg_e leg_q, leg_d;
    logic turn_off;

    assign turn_off = (leg_q == LEG_HIGH && !raw) || (leg_q == LEG_LOW && raw);
    assign load     = turn_off && !zero_dt;

    always_comb begin
        leg_d = leg_q;
        if (turn_off) begin
            leg_d = zero_dt ? leg_for(raw) : LEG_IDLE;
        end else if (leg_q == LEG_IDLE && expired) begin
            leg_d = leg_for(raw);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) leg_q <= LEG_IDLE;
        else     leg_q <= leg_d;
    end

    assign leg = leg_q;

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (leg_q == LEG_IDLE && !expired) |=> (leg_q == LEG_IDLE));

    a_r2_steady_hold: assert property (@(posedge clk) disable iff (rst)
        (leg_q == leg_for(raw)) |=> (leg_q == $past(leg_q)));

endmodule

// File: rtl/dt_comp_pair.sv
module dt_comp_pair
    import dt_pkg::*;
#(
    parameter int CODE_W    = DT_CODE_W,
    parameter int STEP_CLKS = DT_STEP_CLKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_raw,
    input  logic [CODE_W-1:0] dt_code,
    output logic              drv_hi,
    output logic              drv_lo
);

    localparam int MAX_CLKS = ((1 << CODE_W) - 1) * STEP_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP_CLKS);

    logic [CNT_W-1:0] interval;
    logic             zero_dt;
    logic             load;
    logic             expired;
    leg_e             leg;

    assign interval = CNT_W'(dt_code) * STEP_V;
    assign zero_dt  = (dt_code == '0);

    dt_interval_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (interval),
        .expired  (expired)
    );

    dt_leg_steer steer_i (
        .clk     (clk),
        .rst     (rst),
        .raw     (pwm_raw),
        .zero_dt (zero_dt),
        .expired (expired),
        .leg     (leg),
        .load    (load)
    );

    assign drv_hi = (leg == LEG_HIGH);
    assign drv_lo = (leg == LEG_LOW);

    a_r8_no_overlap: assert property (@(posedge clk)
        !(drv_hi && drv_lo));

    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (!drv_hi && !drv_lo));

    a_r3_guard_start: assert property (@(posedge clk) disable iff (rst)
        ((drv_hi && !pwm_raw) || (drv_lo && pwm_raw)) && !zero_dt
        |=> (!drv_hi && !drv_lo));

    a_r4_direct_switch: assert property (@(posedge clk) disable iff (rst)
        (drv_hi && !pwm_raw && zero_dt) |=> drv_lo);

endmodule

// File: tb/dt_comp_pair_tb_top.sv
module dt_comp_pair_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst;
    logic       pwm_raw;
    logic [2:0] dt_code;
    logic       drv_hi;
    logic       drv_lo;

    int n_checks = 0;
    int n_errors = 0;
    int n_overlap = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dt_comp_pair dut_i (
        .clk     (clk),
        .rst     (rst),
        .pwm_raw (pwm_raw),
        .dt_code (dt_code),
        .drv_hi  (drv_hi),
        .drv_lo  (drv_lo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (drv_hi && drv_lo) n_overlap++;
    endtask

    task automatic settle(input logic level, input logic [2:0] code);
        dt_code = code;
        pwm_raw = level;
        for (int i = 0; i < 40; i++) tick();
    endtask

    // R1: reset drives both low; first edge after release needs no guard
    task automatic t_reset();
        rst = 1'b1;
        pwm_raw = 1'b1;
        dt_code = 3'd7;
        for (int i = 0; i < 3; i++) tick();
        check(!drv_hi && !drv_lo, "R1 low during reset", {drv_hi, drv_lo}, 0);
        rst = 1'b0;
        tick();
        check(drv_hi && !drv_lo, "R1 first edge after reset", {drv_hi, drv_lo}, 2);
    endtask

    // R3/R4: cycles from raw change to the new drive turning on
    task automatic t_guard(input logic [2:0] code, input logic to_level);
        int waited;
        int expect_n;
        logic seen;
        settle(!to_level, code);
        pwm_raw = to_level;
        waited = 0;
        seen = 1'b0;
        expect_n = 2 * int'(code) + 1;
        for (int i = 1; i <= 40 && !seen; i++) begin
            tick();
            if (i == 1 && code != 0)
                check(!drv_hi && !drv_lo, "R3 both low after turn-off", {drv_hi, drv_lo}, 0);
            if ((to_level && drv_hi) || (!to_level && drv_lo)) begin
                seen = 1'b1;
                waited = i;
            end
        end
        if (code == 0)
            check(waited == 1, "R4 direct switch", waited, 1);
        else
            check(waited == expect_n, "R3 guard length", waited, expect_n);
        check((to_level ? !drv_lo : !drv_hi), "R2 complement after switch", {drv_hi, drv_lo}, to_level ? 2 : 1);
    endtask

    // R5: constant high raw level stays on with no guard
    task automatic t_steady();
        int lows = 0;
        settle(1'b1, 3'd5);
        for (int i = 0; i < 600; i++) begin
            tick();
            if (!drv_hi || drv_lo) lows++;
        end
        check(lows == 0, "R5 full duty uninterrupted", lows, 0);
        settle(1'b0, 3'd5);
        lows = 0;
        for (int i = 0; i < 600; i++) begin
            tick();
            if (!drv_lo || drv_hi) lows++;
        end
        check(lows == 0, "R5 zero duty uninterrupted", lows, 0);
    endtask

    // R6/R7: short pulses suppressed, longer ones shortened
    task automatic t_pulse(input logic [2:0] code, input int p);
        int hi_n = 0;
        int gap_n = 0;
        int l = 2 * int'(code);
        int exp_hi;
        int exp_gap;
        settle(1'b0, code);
        pwm_raw = 1'b1;
        for (int i = 1; i <= p + 40; i++) begin
            tick();
            if (drv_hi) hi_n++;
            if (!drv_hi && !drv_lo) gap_n++;
            if (i == p) pwm_raw = 1'b0;
        end
        exp_hi  = (p > l) ? p - l : 0;
        exp_gap = (p > l) ? 2 * l : l;
        if (p > l) begin
            check(hi_n == exp_hi, "R7 on-time shortened", hi_n, exp_hi);
            check(gap_n == exp_gap, "R7 two guard intervals", gap_n, exp_gap);
        end else begin
            check(hi_n == 0, "R6 short pulse suppressed", hi_n, 0);
            check(gap_n == exp_gap, "R6 single guard interval", gap_n, exp_gap);
        end
        check(drv_lo && !drv_hi, "R6 low side resumes", {drv_hi, drv_lo}, 1);
    endtask

    // R9: code change during an interval leaves it unchanged
    task automatic t_code_change();
        int waited = 0;
        logic seen = 1'b0;
        settle(1'b0, 3'd7);
        pwm_raw = 1'b1;
        for (int i = 1; i <= 40 && !seen; i++) begin
            tick();
            if (i == 3) dt_code = 3'd1;
            if (drv_hi) begin
                seen = 1'b1;
                waited = i;
            end
        end
        check(waited == 15, "R9 interval keeps loaded code", waited, 15);
    endtask

    initial begin
        rst = 1'b1;
        pwm_raw = 1'b0;
        dt_code = 3'd0;
        t_reset();
        t_guard(3'd1, 1'b1);
        t_guard(3'd3, 1'b1);
        t_guard(3'd3, 1'b0);
        t_guard(3'd7, 1'b0);
        t_guard(3'd0, 1'b1);
        t_guard(3'd0, 1'b0);
        t_steady();
        t_pulse(3'd3, 3);
        t_pulse(3'd3, 6);
        t_pulse(3'd3, 7);
        t_pulse(3'd2, 10);
        t_pulse(3'd0, 1);
        t_code_change();
        check(n_overlap == 0, "R8 never both high", n_overlap, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG_CYCLES; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule